// File: doc/BRIEF.md
# Draw Command Queue with Bus-Mapped Entry

This block sits between a 32-bit processor bus and a graphics engine. Each draw command is 64 bits wide, so software sends it as two word writes into a reserved address window. The window is selected by one high address bit that lies far outside the populated memory. Within the window, address bits [9:6] pick a slot. One slot loads the upper word of the command. Another loads the upper word through a packing function that builds a parameter-plane command. A third slot supplies the lower word, and writing it commits the assembled command into a FIFO.

The consumer side takes the oldest command when it signals ready. It receives the command word together with a single-cycle valid pulse and a matching advance pulse. Software polls a status word to decide whether it may send more. Bit 0 is a "can accept" flag that drops while a configurable margin of free entries still remains. Bit 1 is a sticky overflow flag. Bit 2 reports an empty queue, which tells software the engine has no pending work.

Top module: `gfx_cmd_queue`

## Requirements
- R1: A bus write acts on the queue only when `bus_we` is 1 and address bit `WIN_BIT` is 1; any other write leaves the queue contents and status unchanged.
- R2: A window write with address bits [9:6] = 1 pushes the command {upper word, `bus_wdata`} onto the queue tail, with the upper word in bits [63:32].
- R3: A window write with address bits [9:6] = 0 sets the upper word to `bus_wdata`. A later such write replaces an upper word that was never committed. The upper word is kept after a commit, so repeated lower-word writes reuse it.
- R4: A window write with address bits [9:6] = 2 sets the upper word to {2'b10, wdata[29:20], wdata[19:10], wdata[9:0]}, whatever wdata[31:30] holds.
- R5: Window writes with address bits [9:6] in 3..15 change neither the upper word nor the queue.
- R6: Commands leave the queue in the order they were pushed, and up to `DEPTH` commands can be held.
- R7: Status bit 0 is 1 exactly when more than `SLACK` entries are free.
- R8: Status bit 2 is 1 exactly when the queue holds no command, and status bits [31:3] are always 0.
- R9: A push while `DEPTH` commands are stored is dropped, even if a pop happens in the same cycle. The push sets status bit 1, which stays set until reset.
- R10: At a clock edge where `cons_ready` is 1 and the queue is non-empty, the head entry is removed. In the following cycle, `cons_valid` and `cons_next` are 1 for exactly that cycle, with the removed command on `cons_cmd`. While `cons_ready` is 0, no valid pulse is produced.
- R11: After reset, the status word reads 32'h5 and `cons_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | 32 | Bus write data |
| status_word | output | 32 | Status: bit0 can accept, bit1 overflow, bit2 empty |
| cons_ready | input | 1 | Consumer can take a command |
| cons_valid | output | 1 | One-cycle pulse: `cons_cmd` holds a new command |
| cons_next | output | 1 | One-cycle pulse: the read pointer advanced |
| cons_cmd | output | 64 | Command delivered to the consumer |

## Verification
The bench builds the queue with `DEPTH` = 8 and `SLACK` = 3. With these values, every fill level from empty to full, including the point where bit 0 drops, can be stepped through one at a time. A real overflow can also be produced in a few dozen cycles. Extra pushes and pops then move both pointers around the ring several times, so wraparound ordering is exercised. Each slot of the window and a write outside the window are mixed into the fill sequence.

// File: rtl/gcq_pkg.sv
package gcq_pkg;

    localparam int WORD_W   = 32;
    localparam int SLOT_LSB = 6;
    localparam int SLOT_W   = 4;

    localparam logic [SLOT_W-1:0] SLOT_UPPER = 4'd0;
    localparam logic [SLOT_W-1:0] SLOT_LOWER = 4'd1;
    localparam logic [SLOT_W-1:0] SLOT_PLANE = 4'd2;

    localparam logic [1:0] PLANE_KIND = 2'd2;

    typedef enum logic [1:0] {
        WOP_NONE,
        WOP_UPPER,
        WOP_LOWER,
        WOP_PLANE
    } wr_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] upper;
        logic [WORD_W-1:0] lower;
    } cmd_t;

    typedef struct packed {
        logic [28:0] rsvd;
        logic        empty;
        logic        overflow;
        logic        can_accept;
    } status_t;

    // Build the upper word of a parameter-plane command from three 10-bit fields.
    function automatic logic [WORD_W-1:0] plane_word(input logic [WORD_W-1:0] w);
        return {PLANE_KIND, w[29:20], w[19:10], w[9:0]};
    endfunction

endpackage

// File: rtl/gcq_decode.sv
module gcq_decode
    import gcq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WIN_BIT = 31
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output wr_op_e            op
);

    logic [SLOT_W-1:0] slot;
    logic              in_window;
    logic              unused_addr;

    assign slot        = addr[SLOT_LSB +: SLOT_W];
    assign in_window   = we & addr[WIN_BIT];
    assign unused_addr = ^addr;

    always_comb begin
        op = WOP_NONE;
        if (in_window) begin
            unique case (slot)
                SLOT_UPPER: op = WOP_UPPER;
                SLOT_LOWER: op = WOP_LOWER;
                SLOT_PLANE: op = WOP_PLANE;
                default:    op = WOP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gcq_assemble.sv
module gcq_assemble
    import gcq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_op_e            op,
    input  logic [WORD_W-1:0] wdata,
    output logic              push,
    output cmd_t              cmd
);

    logic [WORD_W-1:0] upper_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
        end else begin
            unique case (op)
                WOP_UPPER: upper_q <= wdata;
                WOP_PLANE: upper_q <= plane_word(wdata);
                default:   upper_q <= upper_q;
            endcase
        end
    end

    assign push      = (op == WOP_LOWER);
    assign cmd.upper = upper_q;
    assign cmd.lower = wdata;

endmodule

// File: rtl/gcq_fifo.sv
module gcq_fifo
    import gcq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SLACK = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  cmd_t push_data,
    input  logic pop,
    output cmd_t head,
    output logic empty,
    output logic nearly_full,
    output logic overflow
);

    localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int FULL_MARK = DEPTH - SLACK;

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_push, do_pop, overflow_q;
    cmd_t             store_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (do_push && (wr_ptr == PTR_W'(g))) begin
                    store_q[g] <= push_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            count      <= '0;
            overflow_q <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) overflow_q <= 1'b1;
        end
    end

    assign head        = store_q[rd_ptr];
    assign nearly_full = (count >= CNT_W'(FULL_MARK));
    assign overflow    = overflow_q;

endmodule

// File: rtl/gcq_present.sv
module gcq_present
    import gcq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic empty,
    input  logic ready,
    input  cmd_t head,
    output logic pop,
    output logic valid,
    output logic next,
    output cmd_t cmd
);

    logic valid_q;
    cmd_t cmd_q;

    assign pop = ready & ~empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cmd_q   <= '0;
        end else begin
            valid_q <= pop;
            if (pop) cmd_q <= head;
        end
    end

    assign valid = valid_q;
    assign next  = valid_q;
    assign cmd   = cmd_q;

endmodule

// File: rtl/gfx_cmd_queue.sv
module gfx_cmd_queue
    import gcq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WIN_BIT = 31,
    parameter int DEPTH   = 16,
    parameter int SLACK   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       status_word,
    input  logic              cons_ready,
    output logic              cons_valid,
    output logic              cons_next,
    output logic [63:0]       cons_cmd
);

    wr_op_e  op;
    logic    push, pop, empty, nearly_full, overflow;
    cmd_t    asm_cmd, head, out_cmd;
    status_t stat;

    gcq_decode #(.ADDR_W(ADDR_W), .WIN_BIT(WIN_BIT)) u_decode (
        .we   (bus_we),
        .addr (bus_addr),
        .op   (op)
    );

    gcq_assemble u_assemble (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .wdata (bus_wdata),
        .push  (push),
        .cmd   (asm_cmd)
    );

    gcq_fifo #(.DEPTH(DEPTH), .SLACK(SLACK)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .push        (push),
        .push_data   (asm_cmd),
        .pop         (pop),
        .head        (head),
        .empty       (empty),
        .nearly_full (nearly_full),
        .overflow    (overflow)
    );

    gcq_present u_present (
        .clk   (clk),
        .rst   (rst),
        .empty (empty),
        .ready (cons_ready),
        .head  (head),
        .pop   (pop),
        .valid (cons_valid),
        .next  (cons_next),
        .cmd   (out_cmd)
    );

    always_comb begin
        stat            = '0;
        stat.can_accept = ~nearly_full;
        stat.overflow   = overflow;
        stat.empty      = empty;
    end

    assign status_word = stat;
    assign cons_cmd    = out_cmd;

endmodule

// File: rtl/gfx_cmd_queue_chk.sv
module gfx_cmd_queue_chk #(
    parameter int ADDR_W  = 32,
    parameter int WIN_BIT = 31
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       status_word,
    input logic              cons_ready,
    input logic              cons_valid,
    input logic              cons_next
);

    logic lower_write;
    assign lower_write = bus_we && bus_addr[WIN_BIT] && (bus_addr[9:6] == 4'd1);

    // R2: a commit with no pop leaves the queue non-empty
    a_r2_commit_fills: assert property (@(posedge clk) disable iff (rst)
        (lower_write && !cons_ready) |=> !status_word[2]);

    // R7/R8: the queue cannot be empty while the margin warning is up
    a_r7_flags_consistent: assert property (@(posedge clk) disable iff (rst)
        !status_word[0] |-> !status_word[2]);

    // R8: upper status bits stay clear
    a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        status_word[31:3] == 29'd0);

    // R9: overflow is sticky
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        status_word[1] |=> status_word[1]);

    // R9: overflow can only appear while the margin warning was already up
    a_r9_overflow_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[1]) |-> !$past(status_word[0]));

    // R10: no valid pulse without ready in the cycle before
    a_r10_needs_ready: assert property (@(posedge clk) disable iff (rst)
        !cons_ready |=> !cons_valid);

    // R10: valid only follows a non-empty queue
    a_r10_needs_entry: assert property (@(posedge clk) disable iff (rst)
        status_word[2] |=> !cons_valid);

    // R10: advance pulse accompanies valid
    a_r10_next_with_valid: assert property (@(posedge clk) disable iff (rst)
        cons_valid |-> cons_next);

endmodule

bind gfx_cmd_queue gfx_cmd_queue_chk #(.ADDR_W(ADDR_W), .WIN_BIT(WIN_BIT)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .status_word (status_word),
    .cons_ready  (cons_ready),
    .cons_valid  (cons_valid),
    .cons_next   (cons_next)
);

// File: tb/test_gfx_cmd_queue.sv
`timescale 1ns/1ps
module test_gfx_cmd_queue;

    localparam int DEPTH = 8;
    localparam int SLACK = 3;
    localparam logic [31:0] WIN = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] status_word;
    logic        cons_ready = 1'b0;
    logic        cons_valid, cons_next;
    logic [63:0] cons_cmd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [63:0] model[$];
    logic [31:0] cur_upper = '0;

    always #2 clk = ~clk;

    gfx_cmd_queue #(.ADDR_W(32), .WIN_BIT(31), .DEPTH(DEPTH), .SLACK(SLACK)) i_gfx_cmd_queue (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .status_word(status_word), .cons_ready(cons_ready), .cons_valid(cons_valid),
        .cons_next(cons_next), .cons_cmd(cons_cmd)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slot_addr(input int s);
        return WIN | (32'(s) << 6);
    endfunction

    task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic logic [31:0] exp_status(input int n, input bit ovf);
        return {29'd0, (n == 0), ovf, ((DEPTH - n) > SLACK)};
    endfunction

    task automatic push_cmd(input logic [31:0] lo);
        bus_wr(slot_addr(1), lo);
        if (model.size() < DEPTH) model.push_back({cur_upper, lo});
    endtask

    task automatic pop_check(input string req);
        logic [63:0] e;
        e = model.pop_front();
        @(negedge clk); cons_ready = 1'b1;
        @(negedge clk); cons_ready = 1'b0;
        check(cons_valid && cons_next, req, {62'd0, cons_valid, cons_next}, 64'd3);
        check(cons_cmd == e, req, cons_cmd, e);
        @(negedge clk);
        check(!cons_valid, "R10 pulse width", {63'd0, cons_valid}, 64'd0);
    endtask

    task automatic do_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model.delete();
        cur_upper = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R11 reset state
        check(status_word == 32'h5, "R11 status", {32'd0, status_word}, 64'h5);
        check(!cons_valid, "R11 valid", {63'd0, cons_valid}, 64'd0);

        // R1: write without window bit is ignored
        bus_wr(32'h0000_0040, 32'hDEAD_BEEF);
        bus_wr(32'h0000_0000, 32'h1111_1111);
        check(status_word == 32'h5, "R1 outside window", {32'd0, status_word}, 64'h5);

        // fill the queue one level at a time
        for (int i = 1; i <= DEPTH; i++) begin
            if (i % 2 == 1) bus_wr(slot_addr(0), 32'hBAD0_0000 | 32'(i)); // R3 decoy
            if (i == 3) begin
                bus_wr(slot_addr(2), 32'h4000_0000 | (32'd7 << 20) | (32'd9 << 10) | 32'd5);
                cur_upper = {2'b10, 10'd7, 10'd9, 10'd5}; // R4 packing
            end else begin
                cur_upper = 32'hA000_0000 + 32'(i * 16);
                bus_wr(slot_addr(0), cur_upper);
            end
            if (i == 5) bus_wr(slot_addr(9), 32'h5555_5555); // R5 ignored slot
            if (i == 6) bus_wr(slot_addr(15), 32'h6666_6666); // R5 ignored slot
            push_cmd(32'h0C00_0000 + 32'(i));
            check(status_word == exp_status(i, 1'b0), "R7 R8 fill level",
                  {32'd0, status_word}, {32'd0, exp_status(i, 1'b0)});
        end

        // R9: push into full queue is dropped, overflow sticky
        push_cmd(32'hFFFF_0001);
        check(status_word == exp_status(DEPTH, 1'b1), "R9 overflow",
              {32'd0, status_word}, {32'd0, exp_status(DEPTH, 1'b1)});

        // R10: no ready, no valid
        repeat (4) begin
            @(negedge clk);
            check(!cons_valid, "R10 held without ready", {63'd0, cons_valid}, 64'd0);
        end

        // R6: drain in order, R2/R3/R4/R5 via contents
        for (int i = DEPTH; i >= 1; i--) begin
            pop_check("R6 R2 order");
            check(status_word == exp_status(i - 1, 1'b1), "R7 R8 drain level",
                  {32'd0, status_word}, {32'd0, exp_status(i - 1, 1'b1)});
        end

        // R3: upper word retained across commits
        push_cmd(32'h0000_00A1);
        push_cmd(32'h0000_00A2);
        pop_check("R3 retained upper");
        pop_check("R3 retained upper");

        // R6: wraparound with interleaved traffic
        for (int k = 0; k < 40; k++) begin
            cur_upper = 32'h7000_0000 ^ 32'(k * 977);
            bus_wr(slot_addr(0), cur_upper);
            push_cmd(32'(k) * 32'h0101_0101);
            if (k % 3 == 2) begin
                pop_check("R6 wrap order");
                pop_check("R6 wrap order");
            end
        end
        while (model.size() > 0) pop_check("R6 wrap tail");
        check(status_word == 32'h7, "R9 sticky after drain", {32'd0, status_word}, 64'h7);

        // R11: reset clears overflow
        do_reset();
        @(negedge clk);
        check(status_word == 32'h5, "R11 reset again", {32'd0, status_word}, 64'h5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule